// File: doc/BRIEF.md
# PCI target read responder

This block answers single-data-phase reads on a 32-bit multiplexed address/data bus when it is the addressed target. In the address phase it checks the command lines for an I/O read or a memory read. It compares the address with one of two 256-byte windows, a separate one for each address space. When the address falls in the right window, the block claims the cycle with medium decode timing and fetches the word from the internal register array through a simple read port. It then presents the word with target-ready and ends the cycle. Each active-low strobe is driven high for one cycle before it is released.

The bus strobes are modelled as separate value and output-enable pairs, so the pad ring builds the tri-state drivers. Writes, bursts, retries and parity belong to other blocks.

Top module: `pci_tgt_rd`

## Requirements
- R1: While rst_ni is low, every output enable (ad_oe_o, devsel_oe_o, trdy_oe_o) is 0, devsel_no and trdy_no are 1, and reg_rd_o is 0.
- R2: Only two command codes on cbe_ni in the address phase are claimed. 4'b0010 is an I/O read and is matched against io_base_i. 4'b0110 is a memory read and is matched against mem_base_i. No other code is claimed, and neither is a read whose address lies in the window of the other space.
- R3: An address matches a window when ad_i[31:8] equals base[31:8]. Bits 7:0 of the address are free, and they become reg_addr_o for that transfer.
- R4: An address phase is a clock edge n at which frame_ni is sampled low after it was sampled high at edge n-1. When that address phase hits, devsel_oe_o is 1 and devsel_no is 0 from edge n+1 onward.
- R5: reg_rd_o is high for exactly the one cycle after edge n+1, with reg_addr_o valid. reg_rdata_i is sampled at edge n+2.
- R6: From edge n+3 the block drives trdy_no low with trdy_oe_o high, and ad_oe_o high with ad_o equal to the word sampled under R5. Byte enables on cbe_ni during the data phase have no effect on the data.
- R7: While irdy_ni is sampled high with trdy_no low, the block holds trdy_no low and keeps ad_o and ad_oe_o unchanged (wait states).
- R8: At the edge m where irdy_ni and trdy_no are both sampled low, the transfer completes. For the next cycle, trdy_no and devsel_no are driven high with their enables still 1, and ad_oe_o is 0. After edge m+1 both enables are 0.
- R9: An address phase sampled at edge m+1, the driven-high cycle, is accepted with the same timing as one taken from idle.
- R10: Falling edges of frame_ni between edge n and edge m are ignored. A frame_ni held low across several edges counts as a single address phase, decoded only at its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Cycle frame from the initiator, active low |
| cbe_ni | input | 4 | Command in the address phase, byte enables after it |
| ad_i | input | 32 | Address/data bus as seen by the target |
| irdy_ni | input | 1 | Initiator ready, active low |
| io_base_i | input | 32 | Base of the I/O window (bits 31:8 used for matching) |
| mem_base_i | input | 32 | Base of the memory window (bits 31:8 used for matching) |
| ad_o | output | 32 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Enable for ad_o |
| devsel_no | output | 1 | Device select value, active low |
| devsel_oe_o | output | 1 | Enable for devsel_no |
| trdy_no | output | 1 | Target ready value, active low |
| trdy_oe_o | output | 1 | Enable for trdy_no |
| reg_addr_o | output | 8 | Internal register address (low address bits) |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 32 | Register read data |

## Verification
Two functions can fall in the same cycle. One is the release of a finished transfer, where the strobes are driven high for a cycle. The other is the address phase of the next transfer. The bench starts a new frame in the very cycle after the data handshake and checks that the strobes still go high and then float. It also checks that the new claim follows with unchanged decode timing. A behavioural model in the bench predicts every output on every clock. The register data it feeds in changes every cycle, so a sample taken one cycle early or late shows up as a data mismatch.

// File: rtl/pci_tgt_rd_pkg.sv
package pci_tgt_rd_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam int         NUM_WIN    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_DSEL,
    ST_DWAIT,
    ST_XFER,
    ST_RLS
  } tgt_st_e;

  typedef struct packed {
    logic devsel_oe;
    logic devsel_n;
    logic trdy_oe;
    logic trdy_n;
    logic ad_oe;
    logic reg_rd;
  } tgt_drv_t;

  localparam tgt_drv_t DRV_IDLE = '{devsel_oe: 1'b0, devsel_n: 1'b1, trdy_oe: 1'b0,
                                    trdy_n: 1'b1, ad_oe: 1'b0, reg_rd: 1'b0};

endpackage

// File: rtl/pci_tgt_rd_decode.sv
module pci_tgt_rd_decode
  import pci_tgt_rd_pkg::*;
#(
  parameter int DW      = 32,
  parameter int WIN_LSB = 8
) (
  input  logic [3:0]    cmd_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] io_base_i,
  input  logic [DW-1:0] mem_base_i,
  output logic          hit_o
);

  localparam logic [DW-1:0] WIN_MASK = {{(DW-WIN_LSB){1'b1}}, {WIN_LSB{1'b0}}};

  logic [NUM_WIN-1:0][3:0]    win_cmd;
  logic [NUM_WIN-1:0][DW-1:0] win_base;
  logic [NUM_WIN-1:0]         win_hit;

  assign win_cmd  = {CMD_MEM_RD, CMD_IO_RD};
  assign win_base = {mem_base_i, io_base_i};

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic cmd_ok;
    logic addr_ok;
    assign cmd_ok      = (cmd_i == win_cmd[gi]);
    assign addr_ok     = (((addr_i ^ win_base[gi]) & WIN_MASK) == '0);
    assign win_hit[gi] = cmd_ok & addr_ok;
  end

  assign hit_o = |win_hit;

endmodule

// File: rtl/pci_tgt_rd_seq.sv
module pci_tgt_rd_seq
  import pci_tgt_rd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     frame_ni,
  input  logic     irdy_ni,
  input  logic     hit_i,
  output logic     addr_take_o,
  output logic     data_take_o,
  output tgt_drv_t drv_o
);

  tgt_st_e st_q, st_d;
  logic    frame_q;
  logic    addr_phase;
  logic    can_accept;

  // address phase = first edge with frame low
  assign addr_phase = frame_q & ~frame_ni;
  assign can_accept = (st_q == ST_IDLE) | (st_q == ST_RLS);
  assign addr_take_o = can_accept & addr_phase & hit_i;
  assign data_take_o = (st_q == ST_DSEL);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (addr_take_o) st_d = ST_DEC;
      ST_DEC:   st_d = ST_DSEL;
      ST_DSEL:  st_d = ST_DWAIT;
      ST_DWAIT: st_d = ST_XFER;
      ST_XFER:  if (!irdy_ni) st_d = ST_RLS;
      ST_RLS:   st_d = addr_take_o ? ST_DEC : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_ni;
    end
  end

  always_comb begin
    drv_o = DRV_IDLE;
    unique case (st_q)
      ST_DSEL: begin
        drv_o.devsel_oe = 1'b1;
        drv_o.devsel_n  = 1'b0;
        drv_o.reg_rd    = 1'b1;
      end
      ST_DWAIT: begin
        drv_o.devsel_oe = 1'b1;
        drv_o.devsel_n  = 1'b0;
      end
      ST_XFER: begin
        drv_o.devsel_oe = 1'b1;
        drv_o.devsel_n  = 1'b0;
        drv_o.trdy_oe   = 1'b1;
        drv_o.trdy_n    = 1'b0;
        drv_o.ad_oe     = 1'b1;
      end
      ST_RLS: begin
        // strobes pushed high for one cycle before release
        drv_o.devsel_oe = 1'b1;
        drv_o.trdy_oe   = 1'b1;
      end
      default: drv_o = DRV_IDLE;
    endcase
  end

endmodule

// File: rtl/pci_tgt_rd_datapath.sv
module pci_tgt_rd_datapath #(
  parameter int DW     = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_take_i,
  input  logic              data_take_i,
  input  logic [REG_AW-1:0] addr_lo_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DW-1:0]     data_o
);

  logic [REG_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (addr_take_i) addr_q <= addr_lo_i;
      if (data_take_i) data_q <= rdata_i;
    end
  end

  assign reg_addr_o = addr_q;
  assign data_o     = data_q;

endmodule

// File: rtl/pci_tgt_rd.sv
module pci_tgt_rd
  import pci_tgt_rd_pkg::*;
#(
  parameter int DW      = 32,
  parameter int WIN_LSB = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic [3:0]         cbe_ni,
  input  logic [DW-1:0]      ad_i,
  input  logic               irdy_ni,
  input  logic [DW-1:0]      io_base_i,
  input  logic [DW-1:0]      mem_base_i,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe_o,
  output logic               devsel_no,
  output logic               devsel_oe_o,
  output logic               trdy_no,
  output logic               trdy_oe_o,
  output logic [WIN_LSB-1:0] reg_addr_o,
  output logic               reg_rd_o,
  input  logic [DW-1:0]      reg_rdata_i
);

  localparam int REG_AW = WIN_LSB;

  logic     hit;
  logic     addr_take;
  logic     data_take;
  tgt_drv_t drv;

  pci_tgt_rd_decode #(
    .DW      (DW),
    .WIN_LSB (WIN_LSB)
  ) u_decode (
    .cmd_i      (cbe_ni),
    .addr_i     (ad_i),
    .io_base_i  (io_base_i),
    .mem_base_i (mem_base_i),
    .hit_o      (hit)
  );

  pci_tgt_rd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .irdy_ni     (irdy_ni),
    .hit_i       (hit),
    .addr_take_o (addr_take),
    .data_take_o (data_take),
    .drv_o       (drv)
  );

  pci_tgt_rd_datapath #(
    .DW     (DW),
    .REG_AW (REG_AW)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_take_i (addr_take),
    .data_take_i (data_take),
    .addr_lo_i   (ad_i[REG_AW-1:0]),
    .rdata_i     (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .data_o      (ad_o)
  );

  assign ad_oe_o     = drv.ad_oe;
  assign devsel_no   = drv.devsel_n;
  assign devsel_oe_o = drv.devsel_oe;
  assign trdy_no     = drv.trdy_n;
  assign trdy_oe_o   = drv.trdy_oe;
  assign reg_rd_o    = drv.reg_rd;

endmodule

// File: rtl/pci_tgt_rd_chk.sv
module pci_tgt_rd_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_ni,
  input logic          irdy_ni,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe_o,
  input logic          devsel_no,
  input logic          devsel_oe_o,
  input logic          trdy_no,
  input logic          trdy_oe_o,
  input logic          reg_rd_o
);

  a_r4_claim_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_oe_o) |-> !$past(frame_ni, 2));

  a_r5_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r5_rd_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> (devsel_oe_o && !devsel_no));

  a_r6_trdy_needs_devsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no) |-> (devsel_oe_o && !devsel_no));

  a_r6_ad_with_trdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (trdy_oe_o && !trdy_no));

  a_r7_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no && irdy_ni) |=> (trdy_oe_o && !trdy_no && ad_oe_o && $stable(ad_o)));

  a_r8_drive_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && !trdy_no && !irdy_ni) |=>
      (trdy_oe_o && trdy_no && devsel_oe_o && devsel_no && !ad_oe_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_oe_o && trdy_no) |=> (!trdy_oe_o && !devsel_oe_o));

endmodule

bind pci_tgt_rd pci_tgt_rd_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_ni    (frame_ni),
  .irdy_ni     (irdy_ni),
  .ad_o        (ad_o),
  .ad_oe_o     (ad_oe_o),
  .devsel_no   (devsel_no),
  .devsel_oe_o (devsel_oe_o),
  .trdy_no     (trdy_no),
  .trdy_oe_o   (trdy_oe_o),
  .reg_rd_o    (reg_rd_o)
);

// File: tb/pci_tgt_rd_test.sv
`timescale 1ns/1ps
module pci_tgt_rd_test;

  localparam logic [31:0] IO_BASE  = 32'h0000_1200;
  localparam logic [31:0] MEM_BASE = 32'hFE80_4300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n;
  logic [3:0]  cbe;
  logic [31:0] ad;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int claims = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  pci_tgt_rd uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .cbe_ni(cbe), .ad_i(ad),
    .irdy_ni(irdy_n), .io_base_i(IO_BASE), .mem_base_i(MEM_BASE),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .devsel_no(devsel_n), .devsel_oe_o(devsel_oe),
    .trdy_no(trdy_n), .trdy_oe_o(trdy_oe), .reg_addr_o(reg_addr), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata)
  );

  // register file model: data changes every cycle so sampling time matters
  always @(negedge clk) cyc <= cyc + 1;
  assign reg_rdata = {reg_addr, 8'h5A, cyc[15:0]};

  function automatic bit hit_f(input logic [3:0] c, input logic [31:0] a);
    return (c == 4'b0010 && a[31:8] == IO_BASE[31:8]) ||
           (c == 4'b0110 && a[31:8] == MEM_BASE[31:8]);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 decoding (age 0..2), 2 data, 3 drive-high
  int          mode = 0;
  int          age  = 0;
  logic        fprev = 1'b1;
  logic [7:0]  e_addr = '0;
  logic [31:0] e_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; age = 0; fprev = 1'b1;
    end else begin
      bit new_a;
      new_a = fprev && !frame_n && hit_f(cbe, ad);
      case (mode)
        0: if (new_a) begin mode = 1; age = 0; e_addr = ad[7:0]; end
        1: begin
          age++;
          if (age == 2) e_data = {e_addr, 8'h5A, cyc[15:0]};
          if (age == 3) mode = 2;
        end
        2: if (!irdy_n) mode = 3;
        default: if (new_a) begin mode = 1; age = 0; e_addr = ad[7:0]; end
                 else mode = 0;
      endcase
      fprev = frame_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit x_dsel, x_dsel_oe;
      x_dsel    = (mode == 1 && age >= 1) || mode == 2;
      x_dsel_oe = x_dsel || mode == 3;
      chk("R4", "devsel_oe", devsel_oe, x_dsel_oe);
      chk("R8", "devsel_n", devsel_n, !x_dsel);
      chk("R8", "trdy_oe", trdy_oe, mode == 2 || mode == 3);
      chk("R6", "trdy_n", trdy_n, mode != 2);
      chk("R6", "ad_oe", ad_oe, mode == 2);
      if (mode == 2) chk("R6", "ad_o", ad_o, e_data);
      chk("R5", "reg_rd", reg_rd, mode == 1 && age == 1);
      if (mode == 1 && age == 1) chk("R3", "reg_addr", reg_addr, e_addr);
      if (devsel_oe && !oe_prev) claims++;
      oe_prev = devsel_oe;
    end
  end

  task automatic rd(input logic [3:0] cmd, input logic [31:0] addr, input int waits,
                    input bit exp_hit, input bit no_gap, input bit inject);
    if (!no_gap) @(negedge clk);
    frame_n = 1'b0; cbe = cmd; ad = addr; irdy_n = 1'b1;
    @(negedge clk);
    frame_n = 1'b1; cbe = 4'b1010; ad = addr ^ 32'hCAFE_0000;
    if (exp_hit) begin
      for (int g = 0; g < 20 && !(trdy_oe === 1'b1 && trdy_n === 1'b0); g++) begin
        if (inject && g == 1) begin frame_n = 1'b0; cbe = 4'b0010; ad = IO_BASE + 32'h4; end
        else frame_n = 1'b1;
        @(negedge clk);
      end
      frame_n = 1'b1;
      repeat (waits) @(negedge clk);
      irdy_n = 1'b0;
      @(negedge clk);
      irdy_n = 1'b1;
    end else begin
      irdy_n = 1'b0;
      repeat (5) @(negedge clk);
      irdy_n = 1'b1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe = 4'h0; ad = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ad_oe", ad_oe, 1'b0);
    chk("R1", "devsel_oe", devsel_oe, 1'b0);
    chk("R1", "trdy_oe", trdy_oe, 1'b0);
    chk("R1", "devsel_n", devsel_n, 1'b1);
    chk("R1", "trdy_n", trdy_n, 1'b1);
    chk("R1", "reg_rd", reg_rd, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 I/O read hit, no waits
    rd(4'b0010, IO_BASE + 32'h10, 0, 1, 0, 0);
    chk("R2", "claims io", claims, 1);
    // R3 top byte of memory window, R7 two wait states
    rd(4'b0110, MEM_BASE + 32'hFF, 2, 1, 0, 0);
    chk("R7", "claims waited", claims, 2);
    // R2 cross-space and non-read commands
    rd(4'b0010, MEM_BASE, 0, 0, 0, 0);
    rd(4'b0110, IO_BASE, 0, 0, 0, 0);
    rd(4'b0011, IO_BASE, 0, 0, 0, 0);
    chk("R2", "claims others", claims, 2);
    // R3 just outside the windows
    rd(4'b0010, IO_BASE + 32'h100, 0, 0, 0, 0);
    rd(4'b0110, MEM_BASE - 32'h1, 0, 0, 0, 0);
    chk("R3", "claims outside", claims, 2);
    // R9 next address phase in the drive-high cycle
    rd(4'b0010, IO_BASE + 32'h2C, 1, 1, 0, 0);
    rd(4'b0110, MEM_BASE + 32'h80, 0, 1, 1, 0);
    rd(4'b0010, IO_BASE + 32'hF0, 3, 1, 1, 0);
    chk("R9", "claims chained", claims, 5);
    // R10 frame edge during a response
    rd(4'b0010, IO_BASE + 32'h08, 0, 1, 0, 1);
    chk("R10", "claims inject", claims, 6);
    // R10 frame held low: only the first edge decodes
    @(negedge clk);
    frame_n = 1'b0; cbe = 4'b0111; ad = IO_BASE;
    @(negedge clk); cbe = 4'b0010;
    @(negedge clk);
    @(negedge clk); frame_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10", "claims held frame", claims, 6);
    // R8 final transfer then idle
    rd(4'b0110, MEM_BASE + 32'h44, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R8", "released devsel_oe", devsel_oe, 1'b0);
    chk("R8", "released trdy_oe", trdy_oe, 1'b0);
    chk("R2", "claims final", claims, 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule